// File: doc/BRIEF.md
# Dual-Mixer Digital Phase Timestamper

This block measures the phase of several clocks under test against one common sampling clock whose frequency sits slightly off theirs. Each clock under test is sampled by a single flip-flop running on the sampling clock. That flip-flop acts as a digital mixer: its output toggles at the beat frequency, which is the difference between the two frequencies. The mixer bit then passes through a short settling chain, so that metastable samples can resolve before any logic uses them.

A per-channel estimator finds where each beat edge really lies, even when the edge is surrounded by a burst of glitches. The estimator first waits for a run of identical samples. Only then does it arm itself for the next level change. From the first changed sample it opens a fixed window and counts the samples in that window that still show the old level. The reported edge time is the start of the window plus that count. This is a median-style estimate: a clean step gives the exact step time, and glitch noise spread around the true edge averages out.

All channels share one free-running timestamp counter. Confirmed edges become records that hold the time, the edge direction and the channel number. These records queue in a FIFO, and a simple read strobe drains it.

Top module: `dmtd_stamper`

## Requirements
- R1: The timestamp counter reads 0 during reset and increments by one on every clock edge after reset. When an input bit is sampled at clock edge number i after reset release and forms a clean level change (every later sample in the window keeps the new level), the reported time is i + SYNC_LEN.
- R2: After a window closes, a level change is taken as a new edge only once STABLE_RUN identical settled samples have been seen first. A short pulse that returns before that run is complete produces no record.
- R3: For a noisy transition, the reported time is the time of the first changed sample, plus the number of old-level samples among the WIN_LEN samples that start with that changed sample.
- R4: The polarity bit of a record is 1 for a 0-to-1 edge and 0 for a 1-to-0 edge.
- R5: Channels are estimated independently of one another. When several channels confirm an edge in the same cycle, every record is stored, with the lower channel index first.
- R6: A record has the time in bits [CNT_W-1:0], the polarity in bit CNT_W, and the channel index in the bits above. When rd_en is high and the FIFO is not empty, rd_valid is high on the next cycle, and rd_data then holds the oldest unread record.
- R7: A record that arrives while the FIFO is full is dropped, and the records already stored are kept. The overflow flag is then set, and it stays set until reset.
- R8: After reset, fifo_empty is 1, overflow is 0 and rd_valid is 0.
- R9: For a clean square wave of half-period H samples, two consecutive records of the same channel differ in time by exactly H.
- R10: A rd_en pulse while the FIFO is empty has no effect: rd_valid stays 0 and the FIFO contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Offset sampling clock; the whole block runs on it |
| rst | input | 1 | Synchronous active-high reset |
| clk_ut | input | N_CH | Clocks under test, one bit per channel |
| rd_en | input | 1 | Read strobe for the record FIFO |
| rd_valid | output | 1 | rd_data holds a record read on the previous cycle |
| rd_data | output | CH_W+1+CNT_W | Record: channel, polarity, time |
| fifo_empty | output | 1 | No unread record is stored |
| overflow | output | 1 | Sticky flag: a record was dropped because the FIFO was full |

## Verification
Two channels can confirm an edge in the very same cycle, and both then compete for the single FIFO write port. The bench provokes this by switching both inputs to a new level on the same sample. It expects two records with the same time and the same polarity, channel 0 first and then channel 1, with nothing lost. It also checks that the one-cycle hold in the pending register of the channel that waits does not change the time that channel reports.

// File: rtl/dmtd_pkg.sv
package dmtd_pkg;
  typedef enum logic [1:0] {
    ST_SEEK  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2
  } dg_state_t;
endpackage

// File: rtl/dmtd_mixer.sv
// Digital mixer flop followed by a settling chain of SYNC_LEN stages.
module dmtd_mixer #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ut,
  output logic q
);
  logic                mix;
  logic [SYNC_LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      mix   <= 1'b0;
      chain <= '0;
    end else begin
      mix   <= ut;
      chain <= {chain[SYNC_LEN-2:0], mix};
    end
  end

  assign q = chain[SYNC_LEN-1];
endmodule

// File: rtl/dmtd_deglitch.sv
// Median-style edge estimator: arm in a stable run, then count old-level
// samples over a fixed window opened by the first changed sample.
module dmtd_deglitch
  import dmtd_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int STABLE_RUN = 4,
  parameter int WIN_LEN    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d,
  input  logic [CNT_W-1:0] now,
  output logic             emit,
  output logic [CNT_W-1:0] ts,
  output logic             pol
);
  localparam int RUN_W = $clog2(STABLE_RUN + 1);
  localparam int WIN_W = $clog2(WIN_LEN + 1);

  dg_state_t        state;
  logic             lvl;
  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] idx;
  logic [WIN_W-1:0] olds;
  logic [CNT_W-1:0] start;
  logic             is_old;

  assign is_old = (d == lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SEEK;
      lvl   <= 1'b0;
      run   <= '0;
      idx   <= '0;
      olds  <= '0;
      start <= '0;
      emit  <= 1'b0;
      ts    <= '0;
      pol   <= 1'b0;
    end else begin
      emit <= 1'b0;
      case (state)
        ST_SEEK: begin
          if (is_old) begin
            if (run == RUN_W'(STABLE_RUN - 1)) begin
              state <= ST_ARMED;
              run   <= '0;
            end else begin
              run <= run + 1'b1;
            end
          end else begin
            lvl <= d;
            run <= RUN_W'(1);
          end
        end
        ST_ARMED: begin
          if (!is_old) begin
            start <= now;
            olds  <= '0;
            idx   <= WIN_W'(1);
            state <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (idx == WIN_W'(WIN_LEN - 1)) begin
            emit  <= 1'b1;
            ts    <= start + CNT_W'(olds) + CNT_W'(is_old);
            pol   <= ~lvl;
            lvl   <= ~lvl;
            run   <= '0;
            state <= ST_SEEK;
          end else begin
            olds <= olds + WIN_W'(is_old);
            idx  <= idx + 1'b1;
          end
        end
        default: state <= ST_SEEK;
      endcase
    end
  end

  AST_EMIT_SPACED: assert property (@(posedge clk) disable iff (rst)
    emit |=> !emit); // R2
  AST_STAMP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    emit |-> ((ts - start) < CNT_W'(WIN_LEN))); // R3
  AST_ARM_BEFORE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT && $past(state) != ST_COUNT) |-> ($past(state) == ST_ARMED)); // R2
endmodule

// File: rtl/dmtd_fifo.sv
// Record FIFO with registered read port; drops writes when full.
module dmtd_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr;
  logic [AW:0]  rptr;
  logic         full;
  logic         do_wr;
  logic         do_rd;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      rd_valid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      rd_valid <= do_rd;
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> $stable(wptr)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R7
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> rd_valid); // R6
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> (!rd_valid && $stable(rptr))); // R10
endmodule

// File: rtl/dmtd_stamper.sv
// Multi-channel dual-mixer phase timestamper.
module dmtd_stamper #(
  parameter int N_CH       = 2,
  parameter int CNT_W      = 32,
  parameter int SYNC_LEN   = 2,
  parameter int STABLE_RUN = 4,
  parameter int WIN_LEN    = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int REC_W     = CH_W + 1 + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  clk_ut,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [REC_W-1:0] rd_data,
  output logic             fifo_empty,
  output logic             overflow
);
  logic [CNT_W-1:0] now;
  logic [N_CH-1:0]  settled;
  logic [N_CH-1:0]  emit;
  logic [CNT_W-1:0] emit_ts  [N_CH];
  logic [N_CH-1:0]  emit_pol;
  logic [N_CH-1:0]  pend;
  logic [CNT_W-1:0] pend_ts  [N_CH];
  logic [N_CH-1:0]  pend_pol;
  logic [N_CH-1:0]  grant;
  logic [CH_W-1:0]  sel;
  logic             wr_en;
  logic [REC_W-1:0] wr_rec;

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dmtd_mixer #(.SYNC_LEN(SYNC_LEN)) u_mix (
      .clk (clk),
      .rst (rst),
      .ut  (clk_ut[c]),
      .q   (settled[c])
    );

    dmtd_deglitch #(
      .CNT_W      (CNT_W),
      .STABLE_RUN (STABLE_RUN),
      .WIN_LEN    (WIN_LEN)
    ) u_dg (
      .clk  (clk),
      .rst  (rst),
      .d    (settled[c]),
      .now  (now),
      .emit (emit[c]),
      .ts   (emit_ts[c]),
      .pol  (emit_pol[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        pend[c]     <= 1'b0;
        pend_ts[c]  <= '0;
        pend_pol[c] <= 1'b0;
      end else if (emit[c]) begin
        pend[c]     <= 1'b1;
        pend_ts[c]  <= emit_ts[c];
        pend_pol[c] <= emit_pol[c];
      end else if (grant[c]) begin
        pend[c] <= 1'b0;
      end
    end
  end

  // Fixed priority: lowest pending channel index goes first.
  always_comb begin
    sel = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (pend[c]) sel = CH_W'(c);
    end
  end

  assign grant  = pend & (~pend + 1'b1);
  assign wr_en  = |pend;
  assign wr_rec = {sel, pend_pol[sel], pend_ts[sel]};

  dmtd_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_rec),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .empty    (fifo_empty),
    .overflow (overflow)
  );

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R5
  AST_NO_PEND_CLOBBER: assert property (@(posedge clk) disable iff (rst)
    ((emit & pend & ~grant) == '0)); // R5
  AST_PEND_RETIRED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !emit[sel]) |=> !pend[$past(sel)]); // R5
endmodule

// File: tb/tb_dmtd_stamper.sv
module tb_dmtd_stamper;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 2;
  localparam int SYNC  = 2;
  localparam int RUN   = 4;
  localparam int WIN   = 8;
  localparam int DEPTH = 16;
  localparam int RW    = 1 + 1 + 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ut  = 2'b00;
  logic          rd_en = 1'b0;
  logic          rd_valid;
  logic [RW-1:0] rd_data;
  logic          fifo_empty;
  logic          overflow;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int last_idx = 0;
  int ne = 0;
  int exp_t [64];
  int exp_c [64];
  int exp_p [64];

  dmtd_stamper #(
    .N_CH(NCH), .CNT_W(32), .SYNC_LEN(SYNC), .STABLE_RUN(RUN),
    .WIN_LEN(WIN), .FIFO_DEPTH(DEPTH)
  ) dut (
    .clk(clk), .rst(rst), .clk_ut(ut), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int t, input int c, input int p);
    if (ne < DEPTH) begin
      exp_t[ne] = t; exp_c[ne] = c; exp_p[ne] = p;
      ne++;
    end
  endtask

  // Set both inputs for the next clock edge; last_idx = that edge's number.
  task automatic step(input bit b0, input bit b1, input bit rec);
    bit o0, o1;
    o0 = ut[0]; o1 = ut[1];
    @(negedge clk);
    ut = {b1, b0};
    last_idx = cyc + 1;
    if (rec && b0 != o0) push(last_idx + SYNC, 0, int'(b0));
    if (rec && b1 != o1) push(last_idx + SYNC, 1, int'(b1));
  endtask

  task automatic hold(input int n);
    for (int k = 0; k < n; k++) step(ut[0], ut[1], 1'b0);
  endtask

  task automatic pop_one(input string req, input int k);
    @(negedge clk);
    chk(!fifo_empty, req, "fifo_empty before pop", fifo_empty, 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid, "R6", "rd_valid after pop", rd_valid, 1);
    chk(rd_data[31:0] == exp_t[k], req, "record time", rd_data[31:0], exp_t[k]);
    chk(int'(rd_data[33]) == exp_c[k], req, "record channel", rd_data[33], exp_c[k]);
    chk(int'(rd_data[32]) == exp_p[k], req, "record polarity", rd_data[32], exp_p[k]);
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < ne; k++) pop_one(req, k);
    @(negedge clk);
    chk(fifo_empty, req, "fifo empty after drain", fifo_empty, 1);
    ne = 0;
  endtask

  task automatic do_reset;
    rst = 1'b1; ut = 2'b00; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(fifo_empty == 1'b1, "R8", "fifo_empty at reset", fifo_empty, 1);
    chk(overflow == 1'b0, "R8", "overflow at reset", overflow, 0);
    chk(rd_valid == 1'b0, "R8", "rd_valid at reset", rd_valid, 0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] pat;
    int a;
    do_reset();
    hold(12);

    // R1 R4 R9: two clean square waves with different half-periods (beat offset).
    begin
      int base;
      base = cyc;
      for (int k = 1; k <= 110; k++) begin
        bit s0, s1;
        s0 = (k < 20) ? 1'b0 : (((k - 20) / 20) % 2 == 0);
        s1 = (k < 24) ? 1'b0 : (((k - 24) / 24) % 2 == 0);
        step(s0, s1, 1'b1);
      end
      if (base < 0) $display("unreachable");
    end
    hold(20);
    begin
      // R9: spacing of consecutive ch0 records (indices 0,2,4) equals 20.
      chk(exp_t[2] - exp_t[0] == 20, "R9", "ch0 spacing", exp_t[2] - exp_t[0], 20);
      chk(exp_t[3] - exp_t[1] == 24, "R9", "ch1 spacing", exp_t[3] - exp_t[1], 24);
    end
    drain("R1 R4 R9");

    // R3: glitchy transitions; ch0 is high, ch1 is low here.
    pat = 8'b0001_1010;  // samples (first->last): 0,1,0,1,1,0,0,0 -> 3 old
    for (int k = 0; k < 8; k++) begin
      step(pat[k], ut[1], 1'b0);
      if (k == 0) a = last_idx;
    end
    push(a + SYNC + 3, 0, 0);
    step(1'b0, ut[1], 1'b0);
    hold(10);
    pat = 8'b0111_1011;  // ch1: 1,1,0,1,1,1,1,0 -> 2 old
    for (int k = 0; k < 8; k++) begin
      step(ut[0], pat[k], 1'b0);
      if (k == 0) a = last_idx;
    end
    push(a + SYNC + 2, 1, 1);
    step(ut[0], 1'b1, 1'b0);
    hold(10);
    pat = 8'b1000_0001;  // ch0: 1,0,0,0,0,0,0,1 -> 6 old
    for (int k = 0; k < 8; k++) begin
      step(pat[k], ut[1], 1'b0);
      if (k == 0) a = last_idx;
    end
    push(a + SYNC + 6, 0, 1);
    step(1'b1, ut[1], 1'b0);
    hold(12);
    drain("R3");

    // R5: both channels fall on the same sample.
    step(1'b0, 1'b0, 1'b1);
    hold(15);
    chk(exp_t[0] == exp_t[1], "R5", "same-cycle times equal", exp_t[0], exp_t[1]);
    drain("R5");

    // R2: short pulse right after a window must not yield a record.
    step(1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    hold(20);
    step(1'b0, 1'b0, 1'b1);
    hold(15);
    drain("R2");

    // R7: 20 edges with no reads; only the first DEPTH are kept.
    for (int k = 0; k < 240; k++) step(((k / 12) % 2) == 0, 1'b0, 1'b1);
    hold(20);
    chk(overflow == 1'b1, "R7", "overflow set", overflow, 1);
    drain("R7");
    chk(overflow == 1'b1, "R7", "overflow sticky after drain", overflow, 1);

    // R10: read strobe on empty FIFO.
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R10", "rd_valid on empty read", rd_valid, 0);
    chk(fifo_empty == 1'b1, "R10", "still empty", fifo_empty, 1);

    // R8: reset clears the sticky flag.
    do_reset();
    finish_run();
  end
endmodule